// File: doc/BRIEF.md
# Codec Register Access Controller

This block is a small bus slave through which a host processor reaches the internal registers of an external audio codec. The host sees four 32-bit words: a control word, the codec register number to reach, the value to send, and the value the codec returned. Writing the control word with its go bit set launches one transaction. A write transaction is announced at once on a dedicated interrupt line. A read transaction waits for the codec side to answer, captures the answer, and only then raises a separate interrupt line.

The serial link to the codec itself is not part of the block. In its place is a plain strobe handshake. The controller emits a one-cycle request strobe that carries a direction flag. For reads, the codec side later presents the returned value together with a one-cycle done strobe. Bus accesses that are not full-word, or that fall on unused word slots, leave all state untouched, read back as zero and latch a sticky error flag.

Top module: `codec_reg_ctl`

## Requirements
- R1: After a synchronous reset, all four registers read 0, the error flag is 0, and the strobe and both interrupt outputs are low.
- R2: The word index is the byte address shifted right by two. Index 1 is the codec register number, index 2 is the outgoing value and index 3 is the returned value. Each keeps the last full-word value the host wrote to it until it is overwritten. Read data appears on `bus_rdata` in the cycle after the read is sampled and is 0 in every other cycle.
- R3: Index 0 is the control word. Bit 0 is go and bit 1 is direction (1 = write to codec, 0 = read from codec). The stored control word always has bit 0 cleared and keeps every other written bit.
- R4: A control write with go=1 and direction=1 raises `codec_req` and `irq_wr_done` for exactly the one cycle after the write, with `codec_wr`=1.
- R5: A control write with go=1 and direction=0 raises `codec_req` for one cycle with `codec_wr`=0 and raises no interrupt. The first `codec_done` after that loads `codec_rdata` into index 3 and raises `irq_rd_done` for exactly the cycle after the done. Index 3 already holds the new value in that cycle.
- R6: `codec_done` has no effect while no read is pending: index 3 is unchanged and no interrupt is raised.
- R7: A control write with go=1 while a read is pending starts nothing (no strobe, no interrupt). Its other bits are still stored.
- R8: A control write with go=0 raises neither the strobe nor any interrupt.
- R9: An access to an index from 4 upward, or one whose byte enables are not all set, changes no register and reads 0. It sets `err_flag` from the following cycle, and the flag stays set until reset.
- R10: The two interrupt outputs are never high in the same cycle, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is a legal access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, registered |
| codec_req | output | 1 | One-cycle transaction strobe to the codec side |
| codec_wr | output | 1 | Direction of the last launched transaction |
| codec_addr | output | DATA_W (32) | Codec register number (index 1) |
| codec_wdata | output | DATA_W (32) | Outgoing value (index 2) |
| codec_done | input | 1 | Codec side has answered a read |
| codec_rdata | input | DATA_W (32) | Value returned by the codec |
| irq_wr_done | output | 1 | Pulse for a launched write transaction |
| irq_rd_done | output | 1 | Pulse for a completed read transaction |
| err_flag | output | 1 | Sticky flag for illegal bus accesses |

## Verification
The hardest state to reach is the window in which a read is pending. Inside that window a second go request must be dropped, while a stray done strobe outside it must also be dropped. The bench opens the window with a read request, holds `codec_done` low, and inside the window issues a write request and reads back the control word. It then closes the window with a done strobe and sends a further done strobe once the controller is idle. An illegal-access sweep runs over every unused index and every partial byte-enable pattern on one defined index. Each case checks the victim register by reading it back.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;

    // word slots seen by the host
    typedef enum logic [1:0] {
        SLOT_CTRL  = 2'd0,
        SLOT_CADDR = 2'd1,
        SLOT_DOUT  = 2'd2,
        SLOT_DIN   = 2'd3
    } slot_e;

    localparam int CTL_GO_BIT  = 0;
    localparam int CTL_DIR_BIT = 1;
    localparam int NUM_SLOTS   = 4;

    // decoded bus access
    typedef struct packed {
        logic  wr;   // legal write this cycle
        logic  rd;   // legal read this cycle
        slot_e slot;
    } bus_op_t;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_WAIT = 1'b1
    } xact_state_e;

    function automatic logic slot_defined(input logic [7:0] idx);
        return idx < NUM_SLOTS;
    endfunction

endpackage

// File: rtl/codec_reg_decode.sv
module codec_reg_decode
    import codec_reg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output bus_op_t           op,
    output logic              bad
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             legal;

    assign idx   = addr[ADDR_W-1:2];
    assign legal = slot_defined(8'(idx)) && (&be);

    always_comb begin
        op.wr   = sel && we && legal;
        op.rd   = sel && !we && legal;
        op.slot = slot_e'(idx[1:0]);
        bad     = sel && !legal;
    end
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
    import codec_reg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [DATA_W-1:0] wdata,
    input  logic              din_load,
    input  logic [DATA_W-1:0] din_value,
    output logic              go,
    output logic              go_dir,
    output logic [DATA_W-1:0] caddr_q,
    output logic [DATA_W-1:0] dout_q,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] din_q;
    logic [DATA_W-1:0] sel_val;
    logic              ctrl_wr;

    assign ctrl_wr = op.wr && (op.slot == SLOT_CTRL);
    assign go      = ctrl_wr && wdata[CTL_GO_BIT];
    assign go_dir  = wdata[CTL_DIR_BIT];

    always_comb begin
        unique case (op.slot)
            SLOT_CTRL:  sel_val = ctrl_q;
            SLOT_CADDR: sel_val = caddr_q;
            SLOT_DOUT:  sel_val = dout_q;
            default:    sel_val = din_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            caddr_q <= '0;
            dout_q  <= '0;
            din_q   <= '0;
            rdata   <= '0;
        end else begin
            rdata <= op.rd ? sel_val : '0;
            if (ctrl_wr) begin
                ctrl_q <= wdata;
                ctrl_q[CTL_GO_BIT] <= 1'b0;
            end
            if (op.wr && op.slot == SLOT_CADDR) caddr_q <= wdata;
            if (op.wr && op.slot == SLOT_DOUT)  dout_q  <= wdata;
            // codec answer wins over a host write in the same cycle
            if (din_load)
                din_q <= din_value;
            else if (op.wr && op.slot == SLOT_DIN)
                din_q <= wdata;
        end
    end

    AST_CTRL_GO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op.rd && op.slot == SLOT_CTRL) |=> (rdata[CTL_GO_BIT] == 1'b0)); // R3

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !op.rd |=> (rdata == '0)); // R2
endmodule

// File: rtl/codec_xact_fsm.sv
module codec_xact_fsm
    import codec_reg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic go_dir,
    input  logic codec_done,
    output logic codec_req,
    output logic codec_wr,
    output logic irq_wr_done,
    output logic irq_rd_done,
    output logic din_load
);
    xact_state_e state;

    assign din_load = (state == XS_WAIT) && codec_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= XS_IDLE;
            codec_req   <= 1'b0;
            codec_wr    <= 1'b0;
            irq_wr_done <= 1'b0;
            irq_rd_done <= 1'b0;
        end else begin
            codec_req   <= 1'b0;
            irq_wr_done <= 1'b0;
            irq_rd_done <= 1'b0;
            unique case (state)
                XS_IDLE: begin
                    if (go) begin
                        codec_req <= 1'b1;
                        codec_wr  <= go_dir;
                        if (go_dir) irq_wr_done <= 1'b1;
                        else        state       <= XS_WAIT;
                    end
                end
                default: begin
                    if (codec_done) begin
                        irq_rd_done <= 1'b1;
                        state       <= XS_IDLE;
                    end
                end
            endcase
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        codec_req |=> !codec_req); // R4

    AST_WR_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_wr_done |=> !irq_wr_done); // R10

    AST_RD_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        irq_rd_done |-> $past(codec_done)); // R5

    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(irq_wr_done && irq_rd_done)); // R10

    AST_WR_IRQ_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        irq_wr_done |-> (codec_req && codec_wr)); // R4
endmodule

// File: rtl/codec_reg_ctl.sv
module codec_reg_ctl
    import codec_reg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              codec_req,
    output logic              codec_wr,
    output logic [DATA_W-1:0] codec_addr,
    output logic [DATA_W-1:0] codec_wdata,
    input  logic              codec_done,
    input  logic [DATA_W-1:0] codec_rdata,
    output logic              irq_wr_done,
    output logic              irq_rd_done,
    output logic              err_flag
);
    bus_op_t op;
    logic    bad;
    logic    go;
    logic    go_dir;
    logic    din_load;

    codec_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .be   (bus_be),
        .op   (op),
        .bad  (bad)
    );

    codec_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wdata     (bus_wdata),
        .din_load  (din_load),
        .din_value (codec_rdata),
        .go        (go),
        .go_dir    (go_dir),
        .caddr_q   (codec_addr),
        .dout_q    (codec_wdata),
        .rdata     (bus_rdata)
    );

    codec_xact_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .go          (go),
        .go_dir      (go_dir),
        .codec_done  (codec_done),
        .codec_req   (codec_req),
        .codec_wr    (codec_wr),
        .irq_wr_done (irq_wr_done),
        .irq_rd_done (irq_rd_done),
        .din_load    (din_load)
    );

    always_ff @(posedge clk) begin
        if (rst) err_flag <= 1'b0;
        else if (bad) err_flag <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag); // R9

    AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !(&bus_be)) |=> err_flag); // R9

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && !(&bus_be)) |=> (bus_rdata == '0)); // R9
endmodule

// File: tb/sim_codec_reg_ctl.sv
module sim_codec_reg_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [3:0]        bus_be = 4'hF;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              codec_req, codec_wr, irq_wr_done, irq_rd_done, err_flag;
    logic [DATA_W-1:0] codec_addr, codec_wdata;
    logic              codec_done = 1'b0;
    logic [DATA_W-1:0] codec_rdata = '0;

    int tests = 0;
    int fails = 0;
    logic [DATA_W-1:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_reg_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .codec_req(codec_req), .codec_wr(codec_wr),
        .codec_addr(codec_addr), .codec_wdata(codec_wdata),
        .codec_done(codec_done), .codec_rdata(codec_rdata),
        .irq_wr_done(irq_wr_done), .irq_rd_done(irq_rd_done),
        .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) model[i] = '0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bwr(input int idx, input logic [DATA_W-1:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(idx * 4);
        bus_wdata = d; bus_be = be;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic brd(input int idx, input logic [3:0] be, output logic [DATA_W-1:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(idx * 4); bus_be = be;
        @(posedge clk); #1;
        v = bus_rdata;
        bus_sel = 1'b0; bus_be = 4'hF;
    endtask

    task automatic done_pulse(input logic [DATA_W-1:0] d);
        @(negedge clk); codec_done = 1'b1; codec_rdata = d;
        @(posedge clk); #1;
        codec_done = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        summary();
    end

    initial begin
        logic [DATA_W-1:0] v;
        logic [DATA_W-1:0] pat;
        do_reset();

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            brd(i, 4'hF, v); chk("R1 reset reg", v, '0);
        end
        chk("R1 err", 32'(err_flag), 0);
        chk("R1 outputs", {28'd0, codec_req, irq_wr_done, irq_rd_done, codec_wr}, 0);

        // R2/R3/R8: sweep defined slots, go bit kept clear
        for (int i = 0; i < 4; i++) begin
            pat = (32'h1357_9BDF * (i + 1)) ^ 32'hA5A5_0000;
            pat[0] = 1'b0;
            bwr(i, pat, 4'hF);
            model[i] = pat;
            chk("R8 no strobe", {30'd0, codec_req, irq_wr_done | irq_rd_done}, 0);
        end
        for (int i = 0; i < 4; i++) begin
            brd(i, 4'hF, v); chk("R2 readback", v, model[i]);
        end
        chk("R2 codec_addr", codec_addr, model[1]);
        chk("R2 codec_wdata", codec_wdata, model[2]);
        step(); chk("R2 rdata idle zero", bus_rdata, '0);

        // R9: unused slots, writes ignored, reads zero, sticky error
        chk("R9 err before", 32'(err_flag), 0);
        for (int i = 4; i < 8; i++) begin
            bwr(i, 32'hFFFF_FFFF, 4'hF);
            chk("R9 err set", 32'(err_flag), 1);
            brd(i, 4'hF, v); chk("R9 unused read", v, '0);
        end
        for (int i = 0; i < 4; i++) begin
            brd(i, 4'hF, v); chk("R9 no side effect", v, model[i]);
        end
        // partial byte enables on slot 1
        for (int b = 0; b < 15; b++) begin
            bwr(1, 32'hDEAD_0000 | 32'(b), 4'(b));
            brd(1, 4'(b), v); chk("R9 partial read zero", v, '0);
            brd(1, 4'hF, v); chk("R9 partial write ignored", v, model[1]);
        end
        step(); chk("R9 err still set", 32'(err_flag), 1);
        do_reset();
        chk("R1 err cleared", 32'(err_flag), 0);

        // R4: write transaction
        bwr(1, 32'h0000_002C, 4'hF);
        bwr(2, 32'h0000_8000, 4'hF);
        bwr(0, 32'h0000_00F3, 4'hF);
        chk("R4 strobe", {29'd0, codec_req, codec_wr, irq_wr_done}, 32'b111);
        chk("R4 no rd irq", 32'(irq_rd_done), 0);
        step();
        chk("R4 one cycle", {30'd0, codec_req, irq_wr_done}, 0);
        brd(0, 4'hF, v); chk("R3 go cleared", v, 32'h0000_00F2);

        // R5: read transaction
        bwr(0, 32'h0000_0001, 4'hF);
        chk("R5 strobe", {30'd0, codec_req, codec_wr}, 32'b10);
        chk("R5 no irq yet", {30'd0, irq_wr_done, irq_rd_done}, 0);
        step(); chk("R5 strobe one cycle", 32'(codec_req), 0);
        repeat (3) begin
            step(); chk("R5 waiting no irq", 32'(irq_rd_done), 0);
        end
        // R7: request while read pending
        bwr(0, 32'h0000_0043, 4'hF);
        chk("R7 no strobe", {30'd0, codec_req, irq_wr_done}, 0);
        brd(0, 4'hF, v); chk("R7 ctrl stored", v, 32'h0000_0042);
        done_pulse(32'hCAFE_0001);
        chk("R5 rd irq", 32'(irq_rd_done), 1);
        chk("R10 exclusive", 32'(irq_wr_done), 0);
        step(); chk("R10 rd irq one cycle", 32'(irq_rd_done), 0);
        brd(3, 4'hF, v); chk("R5 din loaded", v, 32'hCAFE_0001);

        // R6: done while idle
        done_pulse(32'h1234_5678);
        chk("R6 no irq", {30'd0, irq_wr_done, irq_rd_done}, 0);
        brd(3, 4'hF, v); chk("R6 din unchanged", v, 32'hCAFE_0001);

        // R8: go=0 write with direction set
        bwr(0, 32'h0000_0002, 4'hF);
        chk("R8 no strobe dir", {29'd0, codec_req, irq_wr_done, irq_rd_done}, 0);

        summary();
    end
endmodule